// File: doc/BRIEF.md
# Segmented Memory Address Selector

This block produces the memory address for every access made by a small 8-bit processor. It holds four segment registers: code, data, extra and stack. On each access it picks one of them according to the access kind and an extra-segment override bit. The chosen segment value becomes the upper byte of a 16-bit address and the access offset becomes the lower byte. When an access is two bytes wide, the block also gives the address of the second byte.

Software moves values into the segment registers through a write port and reads them back through a read port. The address and read paths are combinational from the stored registers, so a write takes effect one cycle later. The block also tracks the data and stack references made within one instruction. It raises an error flag when an instruction asks for a second one.

Top module: `segsel_addr_gen`

## Requirements
- R1: An access of kind fetch (`acc_kind_i` = 2'b00) always takes its upper address byte from the code segment (index 0), whatever the value of `use_extra_i`.
- R2: An access of kind data (2'b01), or of the reserved kind 2'b11, takes the data segment (index 1) when `use_extra_i` is low.
- R3: An access of kind stack (2'b10) takes the stack segment (index 3) when `use_extra_i` is low.
- R4: For the data, reserved and stack kinds, a high `use_extra_i` selects the extra segment (index 2) in place of the default.
- R5: `addr_lo_o` is the selected segment value in bits 15:8 and `offset_i` in bits 7:0. It is formed whether or not `acc_valid_i` is high.
- R6: `addr_hi_o` uses the same segment byte, with the offset plus one wrapping modulo 256 (offset 0xFF gives 0x00). `acc_wide_o` is high exactly when `acc_valid_i` and `acc_wide_i` are both high.
- R7: A write through `seg_wr_en_i` stores `seg_wr_data_i` into segment `seg_wr_sel_i` at the clock edge. In the cycle of the write, the address and the read port still show the old value.
- R8: `seg_rd_data_o` returns the stored value of segment `seg_rd_sel_i`, using the index coding code 0, data 1, extra 2, stack 3.
- R9: A synchronous reset (`rst_i` high at a clock edge) clears all four segment registers to zero and forgets any reference already made.
- R10: `multi_ref_err_o` is high when a valid non-fetch access is made, `insn_start_i` is low, and a valid non-fetch access has already been made since the last instruction start. A fetch never counts as a reference and never raises the flag. An access made with `insn_start_i` high counts as the first reference of the new instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | An access is requested this cycle |
| acc_kind_i | input | 2 | Access kind: 00 fetch, 01 data, 10 stack, 11 treated as data |
| use_extra_i | input | 1 | Extra-segment override for data and stack kinds |
| acc_wide_i | input | 1 | The access is 16 bits wide |
| insn_start_i | input | 1 | First cycle of a new instruction |
| offset_i | input | OFF_W | Offset within the segment |
| seg_wr_en_i | input | 1 | Segment register write enable |
| seg_wr_sel_i | input | 2 | Segment register to write |
| seg_wr_data_i | input | SEG_W | Value to write |
| seg_rd_sel_i | input | 2 | Segment register to read |
| seg_rd_data_o | output | SEG_W | Value of the selected segment register |
| addr_lo_o | output | SEG_W+OFF_W | Address of the first byte |
| addr_hi_o | output | SEG_W+OFF_W | Address of the second byte |
| acc_wide_o | output | 1 | A valid 16-bit access is in progress |
| multi_ref_err_o | output | 1 | A second memory reference was requested in one instruction |

## Verification
The bench builds the block with the default widths: 8-bit segments and 8-bit offsets. With an 8-bit offset, random offsets reach the 0xFF wrap of the second-byte address often, and a directed case also checks it. Two-bit segment selects let random writes and reads cover every register many times. Random writes landing in the same cycle as accesses check the rule that the old value is used.

// File: rtl/segsel_pkg.sv
package segsel_pkg;

    localparam int NUM_SEG   = 4;
    localparam int SEG_IDX_W = $clog2(NUM_SEG);

    typedef logic [SEG_IDX_W-1:0] seg_idx_t;

    localparam seg_idx_t SEG_CODE  = 2'd0;
    localparam seg_idx_t SEG_DATA  = 2'd1;
    localparam seg_idx_t SEG_EXTRA = 2'd2;
    localparam seg_idx_t SEG_STACK = 2'd3;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_DATA  = 2'b01,
        ACC_STACK = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/segsel_regfile.sv
module segsel_regfile
    import segsel_pkg::*;
#(
    parameter int SEG_W = 8
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          wr_en_i,
    input  seg_idx_t                      wr_sel_i,
    input  logic [SEG_W-1:0]              wr_data_i,
    output logic [NUM_SEG-1:0][SEG_W-1:0] seg_o
);

    typedef struct packed {
        logic [NUM_SEG-1:0][SEG_W-1:0] seg;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.seg = '0;
        end else if (wr_en_i) begin
            st_d.seg[wr_sel_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_out
        assign seg_o[g] = st_q.seg[g];
    end

endmodule

// File: rtl/segsel_pick.sv
module segsel_pick
    import segsel_pkg::*;
(
    input  logic [1:0] acc_kind_i,
    input  logic       use_extra_i,
    output seg_idx_t   sel_o
);

    acc_kind_e kind;

    always_comb begin
        kind = acc_kind_e'(acc_kind_i);
        unique case (kind)
            ACC_FETCH: sel_o = SEG_CODE;
            ACC_STACK: sel_o = use_extra_i ? SEG_EXTRA : SEG_STACK;
            ACC_DATA,
            ACC_RSVD:  sel_o = use_extra_i ? SEG_EXTRA : SEG_DATA;
            default:   sel_o = SEG_DATA;
        endcase
    end

endmodule

// File: rtl/segsel_refguard.sv
module segsel_refguard
    import segsel_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       acc_valid_i,
    input  logic [1:0] acc_kind_i,
    input  logic       insn_start_i,
    output logic       err_o
);

    typedef struct packed {
        logic used;
    } guard_state_t;

    guard_state_t st_d, st_q;
    logic         is_ref;

    always_comb begin
        is_ref = acc_valid_i && (acc_kind_e'(acc_kind_i) != ACC_FETCH);
        err_o  = is_ref && st_q.used && !insn_start_i;
        st_d   = st_q;
        if (rst_i) begin
            st_d.used = 1'b0;
        end else if (insn_start_i) begin
            st_d.used = is_ref;
        end else if (is_ref) begin
            st_d.used = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/segsel_addr_gen.sv
module segsel_addr_gen
    import segsel_pkg::*;
#(
    parameter int SEG_W = 8,
    parameter int OFF_W = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     acc_valid_i,
    input  logic [1:0]               acc_kind_i,
    input  logic                     use_extra_i,
    input  logic                     acc_wide_i,
    input  logic                     insn_start_i,
    input  logic [OFF_W-1:0]         offset_i,
    input  logic                     seg_wr_en_i,
    input  logic [1:0]               seg_wr_sel_i,
    input  logic [SEG_W-1:0]         seg_wr_data_i,
    input  logic [1:0]               seg_rd_sel_i,
    output logic [SEG_W-1:0]         seg_rd_data_o,
    output logic [SEG_W+OFF_W-1:0]   addr_lo_o,
    output logic [SEG_W+OFF_W-1:0]   addr_hi_o,
    output logic                     acc_wide_o,
    output logic                     multi_ref_err_o
);

    localparam int ADDR_W = SEG_W + OFF_W;

    logic [NUM_SEG-1:0][SEG_W-1:0] seg_vals;
    seg_idx_t                      sel;
    logic [SEG_W-1:0]              seg_cur;
    logic [OFF_W-1:0]              offset_next;

    segsel_regfile #(.SEG_W(SEG_W)) u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (seg_wr_en_i),
        .wr_sel_i  (seg_wr_sel_i),
        .wr_data_i (seg_wr_data_i),
        .seg_o     (seg_vals)
    );

    segsel_pick u_pick (
        .acc_kind_i  (acc_kind_i),
        .use_extra_i (use_extra_i),
        .sel_o       (sel)
    );

    segsel_refguard u_guard (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .acc_valid_i  (acc_valid_i),
        .acc_kind_i   (acc_kind_i),
        .insn_start_i (insn_start_i),
        .err_o        (multi_ref_err_o)
    );

    always_comb begin
        seg_cur       = seg_vals[sel];
        offset_next   = offset_i + OFF_W'(1);
        addr_lo_o     = {seg_cur, offset_i};
        addr_hi_o     = {seg_cur, offset_next};
        acc_wide_o    = acc_valid_i && acc_wide_i;
        seg_rd_data_o = seg_vals[seg_rd_sel_i];
    end

    logic [ADDR_W-1:0] unused_width_probe;
    assign unused_width_probe = '0;

endmodule

// File: rtl/segsel_addr_gen_chk.sv
module segsel_addr_gen_chk #(
    parameter int SEG_W = 8,
    parameter int OFF_W = 8
) (
    input logic                        clk_i,
    input logic                        rst_i,
    input logic                        acc_valid_i,
    input logic [1:0]                  acc_kind_i,
    input logic                        use_extra_i,
    input logic                        insn_start_i,
    input logic                        seg_wr_en_i,
    input logic [1:0]                  seg_wr_sel_i,
    input logic [SEG_W-1:0]            seg_wr_data_i,
    input logic [SEG_W+OFF_W-1:0]      addr_lo_o,
    input logic [SEG_W+OFF_W-1:0]      addr_hi_o,
    input logic                        acc_wide_o,
    input logic                        multi_ref_err_o,
    input logic [3:0][SEG_W-1:0]       seg_vals
);

    localparam int AW = SEG_W + OFF_W;

    a_r1_fetch_code: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_valid_i && acc_kind_i == 2'b00) |-> addr_lo_o[AW-1:OFF_W] == seg_vals[0]);

    a_r4_extra_override: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_valid_i && use_extra_i && acc_kind_i != 2'b00) |-> addr_lo_o[AW-1:OFF_W] == seg_vals[2]);

    a_r6_second_byte: assert property (@(posedge clk_i) disable iff (rst_i)
        acc_wide_o |-> (addr_hi_o[AW-1:OFF_W] == addr_lo_o[AW-1:OFF_W]) &&
                       (addr_hi_o[OFF_W-1:0] == OFF_W'(addr_lo_o[OFF_W-1:0] + OFF_W'(1))));

    a_r7_write_lands: assert property (@(posedge clk_i) disable iff (rst_i)
        seg_wr_en_i |=> seg_vals[$past(seg_wr_sel_i)] == $past(seg_wr_data_i));

    a_r9_reset_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> seg_vals == '0);

    a_r10_err_cause: assert property (@(posedge clk_i) disable iff (rst_i)
        multi_ref_err_o |-> (acc_valid_i && acc_kind_i != 2'b00 && !insn_start_i));

endmodule

bind segsel_addr_gen segsel_addr_gen_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_chk (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .acc_valid_i     (acc_valid_i),
    .acc_kind_i      (acc_kind_i),
    .use_extra_i     (use_extra_i),
    .insn_start_i    (insn_start_i),
    .seg_wr_en_i     (seg_wr_en_i),
    .seg_wr_sel_i    (seg_wr_sel_i),
    .seg_wr_data_i   (seg_wr_data_i),
    .addr_lo_o       (addr_lo_o),
    .addr_hi_o       (addr_hi_o),
    .acc_wide_o      (acc_wide_o),
    .multi_ref_err_o (multi_ref_err_o),
    .seg_vals        (seg_vals)
);

// File: tb/segsel_addr_gen_tb_top.sv
module segsel_addr_gen_tb_top;

    localparam int SEG_W = 8;
    localparam int OFF_W = 8;
    localparam int AW    = SEG_W + OFF_W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst = 1'b1;
    logic             acc_valid = 0, use_extra = 0, acc_wide = 0, insn_start = 0;
    logic [1:0]       acc_kind = 0;
    logic [OFF_W-1:0] offset = 0;
    logic             wr_en = 0;
    logic [1:0]       wr_sel = 0, rd_sel = 0;
    logic [SEG_W-1:0] wr_data = 0;
    logic [SEG_W-1:0] rd_data;
    logic [AW-1:0]    addr_lo, addr_hi;
    logic             wide_o, err_o;

    segsel_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W)) dut_i (
        .clk_i(clk), .rst_i(rst), .acc_valid_i(acc_valid), .acc_kind_i(acc_kind),
        .use_extra_i(use_extra), .acc_wide_i(acc_wide), .insn_start_i(insn_start),
        .offset_i(offset), .seg_wr_en_i(wr_en), .seg_wr_sel_i(wr_sel),
        .seg_wr_data_i(wr_data), .seg_rd_sel_i(rd_sel), .seg_rd_data_o(rd_data),
        .addr_lo_o(addr_lo), .addr_hi_o(addr_hi), .acc_wide_o(wide_o),
        .multi_ref_err_o(err_o)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [SEG_W-1:0] m_seg [4];
    bit m_used = 0;

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(logic [1:0] kind, logic extra);
        if (kind == 2'b00) return 2'd0;
        if (extra)         return 2'd2;
        if (kind == 2'b10) return 2'd3;
        return 2'd1;
    endfunction

    function automatic string sel_tag(logic [1:0] kind, logic extra);
        if (kind == 2'b00) return "R1/R5";
        if (extra)         return "R4/R5";
        if (kind == 2'b10) return "R3/R5";
        return "R2/R5";
    endfunction

    // Checks outputs mid-cycle, then advances one clock and updates the model.
    task automatic step();
        logic [1:0]       s;
        logic [SEG_W-1:0] sv;
        bit               is_ref;
        #1;
        s      = exp_sel(acc_kind, use_extra);
        sv     = m_seg[s];
        is_ref = acc_valid && acc_kind != 2'b00;
        check(sel_tag(acc_kind, use_extra), 32'(addr_lo), 32'({sv, offset}));
        check("R6 hi", 32'(addr_hi), 32'({sv, OFF_W'(offset + 1)}));
        check("R6 flag", 32'(wide_o), 32'(acc_valid && acc_wide));
        check("R10", 32'(err_o), 32'(is_ref && m_used && !insn_start));
        check("R8", 32'(rd_data), 32'(m_seg[rd_sel]));
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 4; i++) m_seg[i] = '0;
            m_used = 0;
        end else begin
            if (wr_en) m_seg[wr_sel] = wr_data;
            if (insn_start) m_used = is_ref;
            else if (is_ref) m_used = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        acc_valid = 0; use_extra = 0; acc_wide = 0; insn_start = 0; wr_en = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_seg[i] = 8'hA5;
        void'($urandom(32'h5EED));
        @(negedge clk);
        rst = 1;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        for (int i = 0; i < 4; i++) m_seg[i] = '0;
        rst = 0;
        // R9: every register reads zero after reset
        for (int i = 0; i < 4; i++) begin
            rd_sel = 2'(i);
            #1 check("R9", 32'(rd_data), 32'h0);
            step();
        end
        // R7: write code segment while fetching; old value used this cycle
        acc_valid = 1; acc_kind = 2'b00; offset = 8'h34;
        wr_en = 1; wr_sel = 2'd0; wr_data = 8'h12; rd_sel = 2'd0;
        #1 check("R7 same", 32'(addr_lo), 32'h0034);
        check("R7 rd", 32'(rd_data), 32'h00);
        step();
        wr_en = 0;
        #1 check("R7 next", 32'(addr_lo), 32'h1234);
        step();
        // load other segments
        wr_en = 1; acc_valid = 0;
        wr_sel = 2'd1; wr_data = 8'hD0; step();
        wr_sel = 2'd2; wr_data = 8'hE0; step();
        wr_sel = 2'd3; wr_data = 8'h5A; step();
        idle();
        // R6: wide access wraps offset within the segment
        acc_valid = 1; acc_kind = 2'b01; acc_wide = 1; offset = 8'hFF; insn_start = 1;
        #1 check("R6 wrap", 32'(addr_hi), 32'hD000);
        check("R6 lo", 32'(addr_lo), 32'hD0FF);
        step();
        // R10: second reference in same instruction
        insn_start = 0; acc_kind = 2'b10; acc_wide = 0; offset = 8'h10;
        #1 check("R10 second", 32'(err_o), 32'h1);
        check("R3", 32'(addr_lo), 32'h5A10);
        step();
        acc_kind = 2'b00; use_extra = 1;
        #1 check("R10 fetch", 32'(err_o), 32'h0);
        check("R1 extra ignored", 32'(addr_lo), 32'h1210);
        step();
        insn_start = 1; acc_kind = 2'b10;
        #1 check("R10 new insn", 32'(err_o), 32'h0);
        check("R4 stack", 32'(addr_lo), 32'hE010);
        step();
        insn_start = 0; acc_kind = 2'b11; use_extra = 0; acc_valid = 1;
        #1 check("R2 reserved", 32'(addr_lo), 32'hD010);
        step();
        // random phase
        for (int n = 0; n < 4000; n++) begin
            rst        = ($urandom_range(0, 199) == 0);
            acc_valid  = 1'($urandom);
            acc_kind   = 2'($urandom);
            use_extra  = 1'($urandom);
            acc_wide   = 1'($urandom);
            insn_start = ($urandom_range(0, 2) == 0);
            offset     = ($urandom_range(0, 7) == 0) ? 8'hFF : 8'($urandom);
            wr_en      = 1'($urandom);
            wr_sel     = 2'($urandom);
            wr_data    = 8'($urandom);
            rd_sel     = 2'($urandom);
            step();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule